// File: doc/BRIEF.md
# General-Purpose Event Register Block with Hotplug SCI

This block gives a host a small byte-wide register window of general-purpose event flags. It also drives a level-sensitive system control interrupt (SCI) for one chosen event, the hotplug event. The window is split into two halves. The low half holds status bytes, which hardware event inputs set and the host clears by writing 1s. The high half holds the matching enable bytes, which the host can read and write freely.

Status bit 3 together with enable bit 3 raises the SCI line and sets an internal "asserted" flag. The line can be dropped in two ways, and they leave the flag in different states:

- Clearing the hotplug status drops the line but keeps the flag. While the flag is still set, later hotplug events do not raise the line again.
- Writing the hotplug enable to 0 drops the line and also clears the flag.

A second, separate 32-byte window returns a processor-presence bitmap to the host, which can only read it. The platform updates the bitmap one bit at a time through a side port.

Top module: `gpe_sci_ctrl`

## Requirements
- R1: With `gpe_cs` high, offsets 0 and 1 address status bytes 0 and 1, and offsets 2 and 3 address enable bytes 0 and 1. Any other offset reads 0 and ignores writes. When both selects are high, `gpe_cs` takes priority.
- R2: A high bit of `evt_set` (bit n maps to status byte n/8, bit n%8) sets that status bit at the next clock edge. A bus write to a status byte clears each bit written as 1 and keeps every bit written as 0.
- R3: A bus write to an enable byte replaces that byte completely, and the new value reads back on the next cycle.
- R4: If an event sets a status bit in the same cycle as a write-1 that would clear it, the bit ends up set.
- R5: At the edge where status bit 3 and enable bit 3 of byte 0 are both 1 and the asserted flag is clear, `sci_out` goes high and the flag is set.
- R6: If the flag is set, status bit 3 was 1, and a status write leaves it at 0, `sci_out` goes low and the flag stays set. Later hotplug events then do not raise `sci_out` until the flag is cleared.
- R7: If the flag is set and a write to enable byte 0 leaves bit 3 at 0, `sci_out` goes low and the flag is cleared. An enable write that keeps bit 3 at 1 leaves `sci_out` unchanged.
- R8: With `cpu_cs` high (and `gpe_cs` low), offset k reads bitmap bits 8k+7..8k. Bus writes to this window never change the bitmap.
- R9: A pulse on `cpu_set_we` writes `cpu_set_val` into bitmap bit `cpu_set_idx`. An index of 256 or more is ignored.
- R10: After reset, all status bytes, all enable bytes, the flag and `sci_out` are 0, and bitmap byte 0 reads 0x01 while every other bitmap byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpe_cs | input | 1 | Selects the event register window |
| cpu_cs | input | 1 | Selects the processor bitmap window |
| bus_addr | input | 5 | Byte offset within the selected window |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte (combinational) |
| evt_set | input | 16 | Hardware event set pulses, one per status bit |
| cpu_set_we | input | 1 | Side-port write strobe for the bitmap |
| cpu_set_idx | input | 9 | Bitmap bit index for the side port |
| cpu_set_val | input | 1 | Value written to the indexed bitmap bit |
| sci_out | output | 1 | Level SCI line for the hotplug event |

## Verification
The hardest state to reach is the latched-flag state: the flag is set but the line is low because the hotplug status was cleared. In that state a fresh hotplug event must leave the line low. The stimulus reaches it by raising SCI, clearing status bit 3, and pulsing the event again. It then writes enable byte 0 with bit 3 cleared, then set again, and checks that only this sequence re-arms the line. A separate cycle has an event pulse and a write-1 to the same status bit in one cycle. A random phase then mixes all bus, event and side-port traffic against the reference model.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_STS  = 2'd1,
      WIN_EN   = 2'd2,
      WIN_CPU  = 2'd3
   } gpe_win_e;
endpackage

// File: rtl/gpe_decode.sv
module gpe_decode
   import gpe_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int HALF      = 2,
   parameter int CPU_BYTES = 32
) (
   input  logic              gpe_cs,
   input  logic              cpu_cs,
   input  logic [ADDR_W-1:0] addr,
   output gpe_win_e          win,
   output logic [ADDR_W-1:0] off
);
   localparam logic [ADDR_W:0] HALF_X = (ADDR_W+1)'(HALF);
   localparam logic [ADDR_W:0] BLK_X  = (ADDR_W+1)'(2*HALF);
   localparam logic [ADDR_W:0] CPU_X  = (ADDR_W+1)'(CPU_BYTES);

   logic [ADDR_W:0] addr_x;
   assign addr_x = {1'b0, addr};

   always_comb begin
      win = WIN_NONE;
      off = addr;
      if (gpe_cs) begin
         if (addr_x < HALF_X) begin
            win = WIN_STS;
         end else if (addr_x < BLK_X) begin
            win = WIN_EN;
            off = ADDR_W'(addr_x - HALF_X);
         end
      end else if (cpu_cs) begin
         if (addr_x < CPU_X) win = WIN_CPU;
      end
   end
endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank #(
   parameter int HALF   = 2,
   parameter int ADDR_W = 5,
   localparam int NBITS = HALF * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sts_we,
   input  logic              en_we,
   input  logic [ADDR_W-1:0] idx,
   input  logic [7:0]        wdata,
   input  logic [NBITS-1:0]  evt,
   output logic [NBITS-1:0]  sts_q,
   output logic [NBITS-1:0]  en_q,
   output logic [NBITS-1:0]  sts_d,
   output logic [NBITS-1:0]  en_d
);
   for (genvar b = 0; b < HALF; b++) begin : g_byte
      logic hit;
      logic [7:0] clr;
      assign hit = (idx == ADDR_W'(b));
      assign clr = (sts_we && hit) ? wdata : 8'h00;
      // a set from hardware overrides a write-1 clear in the same cycle
      assign sts_d[b*8 +: 8] = (sts_q[b*8 +: 8] & ~clr) | evt[b*8 +: 8];
      assign en_d[b*8 +: 8]  = (en_we && hit) ? wdata : en_q[b*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= sts_d;
         en_q  <= en_d;
      end
   end
endmodule

// File: rtl/gpe_sci_logic.sv
module gpe_sci_logic (
   input  logic clk,
   input  logic rst_n,
   input  logic sts_we,
   input  logic en_hp_we,
   input  logic hp_sts_q,
   input  logic hp_sts_d,
   input  logic hp_en_d,
   output logic sci_q,
   output logic flag_q
);
   logic raise, drop_en, drop_sts;

   assign raise    = !flag_q && hp_sts_d && hp_en_d;
   assign drop_en  = flag_q && en_hp_we && !hp_en_d;
   assign drop_sts = flag_q && sts_we && hp_sts_q && !hp_sts_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (raise) begin
         sci_q  <= 1'b1;
         flag_q <= 1'b1;
      end else if (drop_en) begin
         sci_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (drop_sts) begin
         sci_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/gpe_cpu_map.sv
module gpe_cpu_map #(
   parameter int CPU_BYTES = 32,
   localparam int NBITS  = CPU_BYTES * 8,
   localparam int IDX_W  = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic [IDX_W:0]   set_idx,
   input  logic             set_val,
   output logic [NBITS-1:0] map_q
);
   localparam logic [NBITS-1:0] RST_MAP = NBITS'(1);

   logic in_range;
   assign in_range = (set_idx < (IDX_W+1)'(NBITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= RST_MAP;
      end else if (set_we && in_range) begin
         map_q[set_idx[IDX_W-1:0]] <= set_val;
      end
   end
endmodule

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl
   import gpe_pkg::*;
#(
   parameter int BLK_LEN   = 4,
   parameter int CPU_BYTES = 32,
   parameter int HP_BIT    = 3,
   parameter int ADDR_W    = 5,
   localparam int HALF     = BLK_LEN / 2,
   localparam int GPE_BITS = HALF * 8,
   localparam int CPU_BITS = CPU_BYTES * 8,
   localparam int CIDX_W   = $clog2(CPU_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gpe_cs,
   input  logic                cpu_cs,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   input  logic [GPE_BITS-1:0] evt_set,
   input  logic                cpu_set_we,
   input  logic [CIDX_W:0]     cpu_set_idx,
   input  logic                cpu_set_val,
   output logic                sci_out
);
   localparam int HP_BYTE = HP_BIT / 8;

   if (BLK_LEN < 2 || (BLK_LEN % 2) != 0) begin : g_chk_len
      $error("BLK_LEN must be even and at least 2");
   end
   if (HP_BIT >= GPE_BITS) begin : g_chk_hp
      $error("HP_BIT outside the status half");
   end
   if ((1 << ADDR_W) < CPU_BYTES || (1 << ADDR_W) < BLK_LEN) begin : g_chk_aw
      $error("ADDR_W too narrow for the windows");
   end

   gpe_win_e            win;
   logic [ADDR_W-1:0]   off;
   logic [GPE_BITS-1:0] sts_q, en_q, sts_d, en_d;
   logic [CPU_BITS-1:0] cpu_map;
   logic                sci_flag;
   logic                sts_we, en_we, en_hp_we;

   gpe_decode #(.ADDR_W(ADDR_W), .HALF(HALF), .CPU_BYTES(CPU_BYTES)) u_dec (
      .gpe_cs (gpe_cs),
      .cpu_cs (cpu_cs),
      .addr   (bus_addr),
      .win    (win),
      .off    (off)
   );

   assign sts_we   = bus_wr && (win == WIN_STS);
   assign en_we    = bus_wr && (win == WIN_EN);
   assign en_hp_we = en_we && (off == ADDR_W'(HP_BYTE));

   gpe_status_bank #(.HALF(HALF), .ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .sts_we (sts_we),
      .en_we  (en_we),
      .idx    (off),
      .wdata  (bus_wdata),
      .evt    (evt_set),
      .sts_q  (sts_q),
      .en_q   (en_q),
      .sts_d  (sts_d),
      .en_d   (en_d)
   );

   gpe_sci_logic u_sci (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_we   (sts_we),
      .en_hp_we (en_hp_we),
      .hp_sts_q (sts_q[HP_BIT]),
      .hp_sts_d (sts_d[HP_BIT]),
      .hp_en_d  (en_d[HP_BIT]),
      .sci_q    (sci_out),
      .flag_q   (sci_flag)
   );

   gpe_cpu_map #(.CPU_BYTES(CPU_BYTES)) u_cpu (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (cpu_set_we),
      .set_idx (cpu_set_idx),
      .set_val (cpu_set_val),
      .map_q   (cpu_map)
   );

   always_comb begin
      bus_rdata = 8'h00;
      unique case (win)
         WIN_STS: for (int b = 0; b < HALF; b++)
            if (off == ADDR_W'(b)) bus_rdata = sts_q[b*8 +: 8];
         WIN_EN: for (int b = 0; b < HALF; b++)
            if (off == ADDR_W'(b)) bus_rdata = en_q[b*8 +: 8];
         WIN_CPU: for (int b = 0; b < CPU_BYTES; b++)
            if (off == ADDR_W'(b)) bus_rdata = cpu_map[b*8 +: 8];
         default: bus_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/gpe_sci_ctrl_chk.sv
module gpe_sci_ctrl_chk #(
   parameter int HALF     = 2,
   parameter int HP_BIT   = 3,
   parameter int ADDR_W   = 5,
   parameter int CPU_BITS = 256
) (
   input logic                clk,
   input logic                rst_n,
   input logic                gpe_cs,
   input logic                cpu_cs,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [7:0]          bus_wdata,
   input logic [HALF*8-1:0]   evt_set,
   input logic                cpu_set_we,
   input logic                sci_out,
   input logic                sci_flag,
   input logic [HALF*8-1:0]   sts_q,
   input logic [HALF*8-1:0]   en_q,
   input logic [CPU_BITS-1:0] cpu_map
);
   localparam logic [ADDR_W-1:0] EN_HP_ADDR = ADDR_W'(HALF + HP_BIT / 8);

   p_rise_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sci_out) |-> (sts_q[HP_BIT] && en_q[HP_BIT]));

   p_line_implies_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sci_out |-> sci_flag);

   p_en_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && gpe_cs && bus_addr == EN_HP_ADDR && !bus_wdata[HP_BIT % 8] && sci_flag)
      |=> (!sci_out && !sci_flag));

   p_cpu_bus_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cpu_cs && !gpe_cs && !cpu_set_we) |=> $stable(cpu_map));

   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && gpe_cs && bus_addr == '0 && evt_set[7:0] == 8'h00)
      |=> ((sts_q[7:0] & $past(bus_wdata)) == 8'h00));

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[HP_BIT] |=> sts_q[HP_BIT]);
endmodule

bind gpe_sci_ctrl gpe_sci_ctrl_chk #(
   .HALF(HALF), .HP_BIT(HP_BIT), .ADDR_W(ADDR_W), .CPU_BITS(CPU_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gpe_cs     (gpe_cs),
   .cpu_cs     (cpu_cs),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .evt_set    (evt_set),
   .cpu_set_we (cpu_set_we),
   .sci_out    (sci_out),
   .sci_flag   (sci_flag),
   .sts_q      (sts_q),
   .en_q       (en_q),
   .cpu_map    (cpu_map)
);

// File: tb/gpe_sci_ctrl_bench.sv
module gpe_sci_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gpe_cs = 1'b0, cpu_cs = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] evt_set = '0;
   logic        cpu_set_we = 1'b0, cpu_set_val = 1'b0;
   logic [8:0]  cpu_set_idx = '0;
   logic        sci_out;

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string phase = "R10";
   bit    mvalid = 0;

   // reference model state
   bit [7:0] m_sts [2];
   bit [7:0] m_en  [2];
   bit [7:0] m_cpu [32];
   bit       m_sci, m_flag;

   always #5 clk = ~clk;

   gpe_sci_ctrl u_gpe_sci_ctrl (
      .clk(clk), .rst_n(rst_n), .gpe_cs(gpe_cs), .cpu_cs(cpu_cs),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .evt_set(evt_set), .cpu_set_we(cpu_set_we),
      .cpu_set_idx(cpu_set_idx), .cpu_set_val(cpu_set_val), .sci_out(sci_out)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_sts[i]) begin m_sts[i] = 0; m_en[i] = 0; end
         foreach (m_cpu[i]) m_cpu[i] = 0;
         m_cpu[0] = 8'h01;
         m_sci = 0; m_flag = 0;
         mvalid = 1;
      end else begin
         bit old_hp, sw, ew;
         bit [7:0] ns [2];
         bit [7:0] ne [2];
         old_hp = m_sts[0][3];
         ns = m_sts; ne = m_en; sw = 0; ew = 0;
         if (bus_wr && gpe_cs) begin
            if (bus_addr < 2) begin ns[bus_addr] &= ~bus_wdata; sw = 1; end
            else if (bus_addr < 4) begin ne[bus_addr-2] = bus_wdata; ew = (bus_addr == 2); end
         end
         ns[0] |= evt_set[7:0];
         ns[1] |= evt_set[15:8];
         if (!m_flag && ns[0][3] && ne[0][3]) begin m_sci = 1; m_flag = 1; end
         else if (m_flag && ew && !ne[0][3]) begin m_sci = 0; m_flag = 0; end
         else if (m_flag && sw && old_hp && !ns[0][3]) m_sci = 0;
         m_sts = ns; m_en = ne;
         if (cpu_set_we && cpu_set_idx < 256)
            m_cpu[cpu_set_idx[7:3]][cpu_set_idx[2:0]] = cpu_set_val;
      end
   end

   function automatic bit [7:0] exp_rd();
      if (gpe_cs) begin
         if (bus_addr < 2) return m_sts[bus_addr];
         if (bus_addr < 4) return m_en[bus_addr-2];
         return 8'h00;
      end
      if (cpu_cs) return m_cpu[bus_addr];
      return 8'h00;
   endfunction

   always @(negedge clk) begin
      if (mvalid && rst_n) begin
         n_cmp++;
         if (bus_rdata !== exp_rd() || sci_out !== m_sci) begin
            n_bad++;
            $display("FAIL %s cyc=%0d addr=%0d rdata=%h exp=%h sci=%b exp=%b",
                     phase, cyc, bus_addr, bus_rdata, exp_rd(), sci_out, m_sci);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
      bus_wr = 0; evt_set = '0; cpu_set_we = 0;
   endtask

   task automatic rd_gpe(input int a);
      gpe_cs = 1; cpu_cs = 0; bus_addr = 5'(a); tick();
   endtask

   task automatic wr_gpe(input int a, input bit [7:0] d);
      gpe_cs = 1; cpu_cs = 0; bus_addr = 5'(a); bus_wdata = d; bus_wr = 1; tick();
   endtask

   task automatic evt(input bit [15:0] e);
      evt_set = e; tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      // R10 reset values
      phase = "R10";
      for (int a = 0; a < 4; a++) rd_gpe(a);
      gpe_cs = 0; cpu_cs = 1;
      for (int a = 0; a < 4; a++) begin bus_addr = 5'(a); tick(); end
      // R1 and R3 layout and enable read/write
      phase = "R3";
      wr_gpe(2, 8'h00); wr_gpe(3, 8'hA5); rd_gpe(3); rd_gpe(2);
      phase = "R1";
      for (int a = 4; a < 8; a++) begin wr_gpe(a, 8'hFF); rd_gpe(a); end
      rd_gpe(3);
      cpu_cs = 1; gpe_cs = 1; bus_addr = 5'd3; tick();
      // R2 event set and write-1-to-clear
      phase = "R2";
      evt(16'h0201); rd_gpe(0); rd_gpe(1);
      wr_gpe(0, 8'h01); rd_gpe(0); wr_gpe(1, 8'h00); rd_gpe(1);
      wr_gpe(1, 8'hFF); rd_gpe(1);
      // R4 set beats clear
      phase = "R4";
      evt(16'h0020);
      evt_set = 16'h0020; wr_gpe(0, 8'h20); rd_gpe(0);
      wr_gpe(0, 8'hFF); rd_gpe(0);
      // R5 raise
      phase = "R5";
      wr_gpe(2, 8'h08); rd_gpe(2);
      evt(16'h0008); rd_gpe(0);
      // R6 status clear drops line, flag kept
      phase = "R6";
      wr_gpe(0, 8'h08); rd_gpe(0);
      evt(16'h0008); rd_gpe(0); rd_gpe(0);
      // R7 enable write keeping bit 3 does nothing, clearing it re-arms
      phase = "R7";
      wr_gpe(2, 8'h0C); rd_gpe(2);
      wr_gpe(2, 8'h00); rd_gpe(2);
      wr_gpe(2, 8'h08); rd_gpe(0);
      wr_gpe(2, 8'h09); wr_gpe(2, 8'h01); rd_gpe(2);
      wr_gpe(0, 8'hFF); wr_gpe(2, 8'h00);
      // R8 processor window read only
      phase = "R8";
      gpe_cs = 0; cpu_cs = 1; bus_addr = 5'd0; bus_wdata = 8'hFF; bus_wr = 1; tick();
      bus_addr = 5'd31; bus_wdata = 8'h5A; bus_wr = 1; tick(); tick();
      bus_addr = 5'd0; tick();
      // R9 side port
      phase = "R9";
      cpu_set_idx = 9'd37; cpu_set_val = 1; cpu_set_we = 1; tick();
      bus_addr = 5'd4; tick();
      cpu_set_idx = 9'd0; cpu_set_val = 0; cpu_set_we = 1; tick();
      bus_addr = 5'd0; tick();
      cpu_set_idx = 9'd255; cpu_set_val = 1; cpu_set_we = 1; tick();
      bus_addr = 5'd31; tick();
      cpu_set_idx = 9'd300; cpu_set_val = 1; cpu_set_we = 1; tick();
      for (int a = 0; a < 32; a++) begin bus_addr = 5'(a); tick(); end
      // mixed traffic across every rule
      phase = "R5";
      for (int i = 0; i < 600; i++) begin
         int unsigned r;
         r = $urandom;
         gpe_cs = (r[1:0] != 0); cpu_cs = r[2];
         bus_addr = gpe_cs ? 5'(r[6:4]) : 5'(r[8:4]);
         bus_wr = r[9] & r[10];
         bus_wdata = 8'($urandom);
         if (r[11] && r[12]) bus_wdata[3] = 1'b0;
         evt_set = (r[15:13] == 0) ? 16'h0008 : ((r[15:13] == 1) ? 16'($urandom) : 16'h0);
         cpu_set_we = r[16] & r[17];
         cpu_set_idx = 9'($urandom);
         cpu_set_val = r[18];
         tick();
      end
      tick();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule